// File: doc/BRIEF.md
# Register Bank Stack Save/Restore Sequencer

This block saves or restores a processor's eight general registers to and from a stack in memory, one word per memory access, after a single start command. The host supplies the register bank as a flat vector, chooses save or restore with one select bit, and pulses start. The sequencer then issues eight word accesses through a request/ready memory port. It returns the final stack pointer and marks completion with a one-cycle done pulse. Restored words appear as per-register write strobes with shared write data, so the strobes can drive the register file directly.

Register index 4 of the bank is the stack pointer, and the stack pointer at the start is read from that slot. During a save, the word stored for slot 4 is the pointer value captured when the operation starts, even if the slot changes later. During a restore, that stack word is fetched and discarded. Segment, instruction-pointer and status state are never touched.

Top module: `regbank_stack_seq`

## Requirements
- R1: A save writes the registers in index order 0,1,2,...,7, one word per access, with mem_we=1.
- R2: The word written for index 4 during a save equals reg_flat slot 4 as sampled in the start cycle. Changes to that slot during the run have no effect.
- R3: A restore reads in index order 7,6,...,0 with mem_we=0. For each index other than 4, rf_we has exactly bit i set (bit i maps to register i) in the same cycle that mem_ready completes the read, and rf_wdata equals mem_rdata in that cycle.
- R4: The restore read for index 4 raises no bit of rf_we.
- R5: A save access goes to the pointer minus 2, and the pointer then moves down by 2. A restore access goes to the pointer, and the pointer then moves up by 2. In the done cycle, sp_out equals the start pointer minus 16 after a save and plus 16 after a restore.
- R6: While mem_req is high and mem_ready is low, mem_req stays high and mem_addr and mem_wdata hold their values into the next cycle.
- R7: done is high for exactly one cycle, which is the cycle after the eighth access completes. busy is high from the cycle after start through the done cycle.
- R8: A start pulse or a change of the select while busy is high has no effect on the access sequence under way.
- R9: Synchronous reset, even in the middle of a run, leaves busy, done, mem_req and rf_we low from the next cycle.
- R10: Pointer and address arithmetic wraps modulo 2^16. For example, a save from pointer 0x0004 writes 0x0002, 0x0000, 0xFFFE and onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only when idle |
| op_restore | input | 1 | 0 = save bank to stack, 1 = restore from stack |
| reg_flat | input | 128 | Register bank, register i in bits [16i+15:16i]; slot 4 is the stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access completes in a cycle where it is high together with mem_req |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| rf_we | output | 8 | Register write strobes for a restore, one bit per register |
| rf_wdata | output | 16 | Data for the strobed register |
| sp_out | output | 16 | Running and final stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step count or a wrong order decode shows on the first accepted access as a wrong address, a wrong write word, or the wrong strobe bit, and it grows worse on each later access. A pointer that slips by one stride shows on the next access address and again in sp_out at done. A snapshot taken in the wrong cycle shows only at the fifth save access, so the bench changes slot 4 after start and inserts wait cycles to make holds and late start pulses visible.

// File: rtl/rss_pkg.sv
package rss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } rss_state_e;
endpackage

// File: rtl/rss_slot_map.sv
module rss_slot_map #(
   parameter int NREG = 8,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [IDX_W-1:0] step,
   input  logic             op_restore_q,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

   // save walks upward, restore walks downward (reverse of save)
   always_comb idx = op_restore_q ? (LAST - step) : step;
endmodule

// File: rtl/rss_ctrl.sv
module rss_ctrl
   import rss_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              op_restore,
   input  logic [DATA_W-1:0] sp_start,
   input  logic              mem_ready,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   output logic [IDX_W-1:0]  step,
   output logic              op_q,
   output logic [DATA_W-1:0] ptr,
   output logic [DATA_W-1:0] sp_snap,
   output logic              acc_fire,
   output logic              busy,
   output logic              done
);
   localparam logic [DATA_W-1:0] STRIDE = DATA_W'(DATA_W / 8);
   localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NREG - 1);

   rss_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         step    <= '0;
         op_q    <= 1'b0;
         ptr     <= '0;
         sp_snap <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state   <= ST_RUN;
               step    <= '0;
               op_q    <= op_restore;
               ptr     <= sp_start;
               sp_snap <= sp_start;
            end
            ST_RUN: if (mem_ready) begin
               ptr <= op_q ? (ptr + STRIDE) : (ptr - STRIDE);
               if (step == LAST) state <= ST_FIN;
               else              step  <= step + 1'b1;
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (state == ST_RUN);
      mem_addr = op_q ? ptr : (ptr - STRIDE);
      acc_fire = mem_req && mem_ready;
      busy     = (state != ST_IDLE);
      done     = (state == ST_FIN);
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
      acc_fire |=> (op_q ? (ptr == $past(ptr) + STRIDE) : (ptr == $past(ptr) - STRIDE)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> ($stable(op_q) && $stable(sp_snap)));

   assert_reset_idle_R9: assert property (@(posedge clk)
      rst |=> (!mem_req && !busy && !done));
endmodule

// File: rtl/rss_datapath.sv
module rss_datapath #(
   parameter int NREG   = 8,
   parameter int DATA_W = 16,
   parameter int SP_IDX = 4,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [IDX_W-1:0]       idx,
   input  logic                   op_q,
   input  logic                   acc_fire,
   input  logic [NREG*DATA_W-1:0] reg_flat,
   input  logic [DATA_W-1:0]      sp_snap,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [DATA_W-1:0]      mem_wdata,
   output logic [NREG-1:0]        rf_we,
   output logic [DATA_W-1:0]      rf_wdata
);
   // save data: live register, except the pointer slot which uses the snapshot
   always_comb begin
      if (idx == IDX_W'(SP_IDX)) mem_wdata = sp_snap;
      else                       mem_wdata = reg_flat[idx*DATA_W +: DATA_W];
      rf_wdata = mem_rdata;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_we
      if (g == SP_IDX) begin : g_sp
         assign rf_we[g] = 1'b0;
      end else begin : g_reg
         assign rf_we[g] = acc_fire && op_q && (idx == IDX_W'(g));
      end
   end

   assert_we_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rf_we));

   assert_we_on_read_R3: assert property (@(posedge clk) disable iff (rst)
      (|rf_we) |-> (acc_fire && op_q));
endmodule

// File: rtl/regbank_stack_seq.sv
module regbank_stack_seq #(
   parameter int NREG   = 8,
   parameter int DATA_W = 16,
   parameter int SP_IDX = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic                   op_restore,
   input  logic [NREG*DATA_W-1:0] reg_flat,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [DATA_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic                   mem_ready,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [NREG-1:0]        rf_we,
   output logic [DATA_W-1:0]      rf_wdata,
   output logic [DATA_W-1:0]      sp_out,
   output logic                   busy,
   output logic                   done
);
   localparam int IDX_W = $clog2(NREG);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_chk_nreg
      $error("NREG must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_chk_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_chk_sp
      $error("SP_IDX out of range");
   end

   logic [IDX_W-1:0]  step, idx;
   logic              op_q, acc_fire;
   logic [DATA_W-1:0] ptr, sp_snap;

   rss_ctrl #(.NREG(NREG), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst(rst), .start(start), .op_restore(op_restore),
      .sp_start(reg_flat[SP_IDX*DATA_W +: DATA_W]), .mem_ready(mem_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .step(step), .op_q(op_q),
      .ptr(ptr), .sp_snap(sp_snap), .acc_fire(acc_fire), .busy(busy), .done(done)
   );

   rss_slot_map #(.NREG(NREG)) u_map (
      .step(step), .op_restore_q(op_q), .idx(idx)
   );

   rss_datapath #(.NREG(NREG), .DATA_W(DATA_W), .SP_IDX(SP_IDX)) u_dp (
      .clk(clk), .rst(rst), .idx(idx), .op_q(op_q), .acc_fire(acc_fire),
      .reg_flat(reg_flat), .sp_snap(sp_snap), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
   );

   assign mem_we = mem_req && !op_q;
   assign sp_out = ptr;
endmodule

// File: tb/regbank_stack_seq_bench.sv
`timescale 1ns/1ps
module regbank_stack_seq_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         op_restore = 1'b0;
   logic [127:0] reg_flat = '0;
   logic         mem_req, mem_we, mem_ready = 1'b0;
   logic [15:0]  mem_addr, mem_wdata, mem_rdata = '0, rf_wdata, sp_out;
   logic [7:0]   rf_we;
   logic         busy, done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   logic [15:0] mem [64];
   logic [15:0] restored [8];

   always #4 clk = ~clk;

   regbank_stack_seq u_regbank_stack_seq (
      .clk(clk), .rst(rst), .start(start), .op_restore(op_restore),
      .reg_flat(reg_flat), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
      .sp_out(sp_out), .busy(busy), .done(done)
   );

   // vector: {op_restore, start pointer, seed}
   localparam logic [24:0] VEC [6] = '{
      {1'b0, 16'h0040, 8'h01},
      {1'b1, 16'h0030, 8'h00},
      {1'b0, 16'h0004, 8'h02},
      {1'b1, 16'hFFF4, 8'h01},
      {1'b0, 16'h1000, 8'h03},
      {1'b1, 16'h0FF0, 8'h02}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] reg_val(input logic [7:0] seed, input int i);
      return {seed, 4'(i), 4'hA};
   endfunction

   task automatic run_op(input logic op, input logic [15:0] sp0, input logic [7:0] seed, input bit poke);
      logic [15:0] ptr, ea, ed;
      int idx, w;
      logic [7:0] ewe;
      @(negedge clk);
      op_restore = op;
      for (int i = 0; i < 8; i++) reg_flat[i*16 +: 16] = (i == 4) ? sp0 : reg_val(seed, i);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      reg_flat[4*16 +: 16] = ~sp0;   // R2: later change must not reach the stack
      #1 check(busy == 1'b1, "R7 busy after start", 32'(busy), 32'd1);
      ptr = sp0;
      for (int k = 0; k < 8; k++) begin
         idx = op ? 7 - k : k;
         ea  = op ? ptr : ptr - 16'd2;
         w   = (k + int'(seed)) % 3;
         for (int c = 0; c < w; c++) begin
            if (poke && c == 0) begin start = 1'b1; op_restore = ~op; end
            #1 check(mem_req && (mem_we == !op) && mem_addr == ea && rf_we == 8'h0,
                     "R6 wait hold", {mem_req, mem_we, 6'h0, rf_we, mem_addr}, {1'b1, !op, 6'h0, 8'h0, ea});
            @(negedge clk);
            start = 1'b0; op_restore = op;
         end
         mem_ready = 1'b1;
         if (op) mem_rdata = mem[ea[6:1]];
         #1;
         check(mem_req && (mem_we == !op), op ? "R3 read access" : "R1 write access",
               {mem_req, mem_we}, {1'b1, !op});
         check(mem_addr == ea, "R5 R10 address", mem_addr, ea);
         if (!op) begin
            ed = (idx == 4) ? sp0 : reg_val(seed, idx);
            check(mem_wdata == ed, (idx == 4) ? "R2 saved pointer" : "R1 save data", mem_wdata, ed);
            mem[ea[6:1]] = mem_wdata;
         end else begin
            ewe = (idx == 4) ? 8'h00 : 8'(1 << idx);
            check(rf_we == ewe, (idx == 4) ? "R4 pointer slot strobe" : "R3 strobe", rf_we, ewe);
            check(rf_wdata == mem_rdata, "R3 restore data", rf_wdata, mem_rdata);
            restored[idx] = rf_wdata;
         end
         ptr = op ? ptr + 16'd2 : ptr - 16'd2;
         @(negedge clk);
         mem_ready = 1'b0;
      end
      #1;
      check(done && busy && !mem_req, "R7 done pulse", {done, busy, mem_req}, 3'b110);
      check(sp_out == (op ? sp0 + 16'd16 : sp0 - 16'd16), "R5 final pointer", sp_out,
            op ? sp0 + 16'd16 : sp0 - 16'd16);
      @(negedge clk);
      #1 check(!done && !busy && !mem_req, "R7 single done", {done, busy, mem_req}, 3'b000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #1 check(!mem_req && !busy && !done && rf_we == 8'h0, "R9 reset state",
               {mem_req, busy, done, rf_we}, 11'h0);
      rst = 1'b0;
      @(negedge clk);
      #1 check(sp_out == 16'h0 && !busy, "R9 idle after reset", {busy, sp_out}, 17'h0);

      for (int v = 0; v < 6; v++)
         run_op(VEC[v][24], VEC[v][23:8], VEC[v][7:0], v == 2 || v == 3);

      // round trip: save then restore must return original values (R3)
      run_op(1'b0, 16'h0020, 8'h55, 1'b0);
      run_op(1'b1, 16'h0010, 8'h00, 1'b1);
      for (int i = 0; i < 8; i++)
         if (i != 4)
            check(restored[i] == reg_val(8'h55, i), "R3 round trip", restored[i], reg_val(8'h55, i));

      // reset in the middle of a run (R9)
      @(negedge clk);
      op_restore = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      #1 check(mem_req == 1'b1, "R9 run started", 32'(mem_req), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1 check(!mem_req && !busy && !done && rf_we == 8'h0, "R9 mid-run reset",
               {mem_req, busy, done, rf_we}, 11'h0);
      @(negedge clk);
      #1 check(!mem_req && !busy, "R9 stays idle", {mem_req, busy}, 2'b00);

      // sequence runs normally after the reset
      run_op(1'b0, 16'h0002, 8'h77, 1'b0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule